// File: doc/BRIEF.md
# Auto-Incrementing Indirect Read Port for ECC Result Registers

This block lets a processor read a bank of sixteen byte-wide internal ECC result slots through one data port and a 4-bit address register. The processor loads the address register. Each read strobe on the data port then captures the byte in the addressed slot into a read-data register and moves the address on by one. A whole bank can therefore be read out with one address write followed by a train of reads. A configuration input can hold the address still, so that one slot can be polled.

The slot contents come in on input buses and are produced elsewhere. The lowest slots hold the syndrome bytes. A run of reserved slots follows. The top six slots hold error pattern and error location pairs. A pair returns its value only while a software-correction request is active and the reported error count is large enough for that pair to exist. Otherwise it returns zero.

Top module: `ecc_ix_port`

## Requirements
- R1: After reset, `addr_q` is 0 and `rd_data` is 0.
- R2: When `addr_we` is high at a clock edge, `addr_q` takes the value of `addr_wdata` at that edge.
- R3: When `data_re` is high, `inc_disable` is low and `addr_we` is low at an edge, `addr_q` becomes its previous value plus one.
- R4: An increment from address 15 wraps to address 0.
- R5: When `data_re` is high and `inc_disable` is high, with no address write, `addr_q` keeps its value.
- R6: If `addr_we` and `data_re` are high at the same edge, `addr_q` takes `addr_wdata`, and `rd_data` captures the byte at the address that applied before that edge.
- R7: The edge on which `data_re` is high loads `rd_data` with the byte at the current address. Addresses 0 to 6 return syndrome byte i, taken from bits [8i+7:8i] of `syn_bus`.
- R8: Addresses 7, 8 and 9 are reserved and read as 0.
- R9: Address 10+2k returns pattern byte k (`pat_bus[8k+7:8k]`), and address 11+2k returns location byte k (`loc_bus[8k+7:8k]`), for k = 0, 1, 2.
- R10: Pair k returns its bytes only while `sw_corr_req` is 1 and `err_cnt` > k. In every other case both slots of that pair read as 0.
- R11: `rd_data` keeps its value on every edge at which `data_re` is low, even when the input buses change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_we | input | 1 | Write strobe for the address register |
| addr_wdata | input | 4 | New address value |
| data_re | input | 1 | Read strobe for the data port |
| inc_disable | input | 1 | Holds the address still on data reads |
| sw_corr_req | input | 1 | Software correction is requested; pattern and location slots are valid |
| err_cnt | input | 2 | Error count in the interleave (3 means three or more) |
| syn_bus | input | 56 | Seven syndrome bytes, byte i at bits [8i+7:8i] |
| pat_bus | input | 24 | Three error pattern bytes |
| loc_bus | input | 24 | Three error location bytes |
| addr_q | output | 4 | Current address register |
| rd_data | output | 8 | Byte captured by the last data read |

## Verification
A full sweep of sixteen reads after one address write tries every slot kind and shows whether the syndrome, reserved and pair slots are ordered correctly and whether the address wraps from 15 to 0. The same slots are then read with the increment disabled. After that, the pair slots are read with the correction request off and with error counts of 1 and 2, which shows whether each pair is masked by its own count threshold and not by the request alone. A read and an address write are issued in the same cycle, which shows both the address priority and the data taken from the old address. Finally the buses change while no read is issued, which shows that the read register holds its value.

// File: rtl/ecc_ix_pkg.sv
package ecc_ix_pkg;

  typedef enum logic [1:0] {
    SLOT_SYN  = 2'd0,
    SLOT_RSVD = 2'd1,
    SLOT_PAT  = 2'd2,
    SLOT_LOC  = 2'd3
  } slot_kind_e;

  // Classify an address given where the syndrome run ends and the pair run starts.
  function automatic slot_kind_e slot_kind(input int unsigned addr,
                                           input int unsigned num_syn,
                                           input int unsigned pair_base);
    if (addr < num_syn)        return SLOT_SYN;
    else if (addr < pair_base) return SLOT_RSVD;
    else if (((addr - pair_base) % 2) == 0) return SLOT_PAT;
    else                       return SLOT_LOC;
  endfunction

endpackage

// File: rtl/ecc_ix_addr_ctr.sv
module ecc_ix_addr_ctr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              inc_fire,
  output logic [ADDR_W-1:0] addr_q
);

  // Write has priority over increment; increment wraps naturally.
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] cur,
                                                  input logic              we,
                                                  input logic [ADDR_W-1:0] wd,
                                                  input logic              inc);
    if (we)       return wd;
    else if (inc) return cur + ADDR_W'(1);
    else          return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= next_addr(addr_q, wr_fire, wdata, inc_fire);
  end

endmodule

// File: rtl/ecc_ix_slot_mux.sv
module ecc_ix_slot_mux
  import ecc_ix_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int NUM_SYN  = 7,
  parameter int NUM_PAIR = 3,
  parameter int CNT_W    = 2
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       sw_corr_req,
  input  logic [CNT_W-1:0]           err_cnt,
  input  logic [NUM_SYN*DATA_W-1:0]  syn_bus,
  input  logic [NUM_PAIR*DATA_W-1:0] pat_bus,
  input  logic [NUM_PAIR*DATA_W-1:0] loc_bus,
  output logic [DATA_W-1:0]          sel_byte,
  output slot_kind_e                 sel_kind
);

  localparam int SLOTS     = 1 << ADDR_W;
  localparam int PAIR_BASE = SLOTS - 2 * NUM_PAIR;

  logic [DATA_W-1:0] slot_tbl [SLOTS];

  // Pair k is present only while correction is requested and count exceeds k.
  function automatic logic pair_live(input logic req, input logic [CNT_W-1:0] cnt,
                                     input int unsigned k);
    return req && (int'(cnt) > int'(k));
  endfunction

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < NUM_SYN) begin : g_syn
      assign slot_tbl[s] = syn_bus[s*DATA_W +: DATA_W];
    end else if (s < PAIR_BASE) begin : g_rsvd
      assign slot_tbl[s] = '0;
    end else begin : g_pair
      localparam int K = (s - PAIR_BASE) / 2;
      if (((s - PAIR_BASE) % 2) == 0) begin : g_pat
        assign slot_tbl[s] = pair_live(sw_corr_req, err_cnt, K) ?
                             pat_bus[K*DATA_W +: DATA_W] : '0;
      end else begin : g_loc
        assign slot_tbl[s] = pair_live(sw_corr_req, err_cnt, K) ?
                             loc_bus[K*DATA_W +: DATA_W] : '0;
      end
    end
  end

  assign sel_byte = slot_tbl[addr];
  assign sel_kind = slot_kind(int'(addr), NUM_SYN, PAIR_BASE);

endmodule

// File: rtl/ecc_ix_port.sv
module ecc_ix_port
  import ecc_ix_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int NUM_SYN  = 7,
  parameter int NUM_PAIR = 3,
  parameter int CNT_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       addr_we,
  input  logic [ADDR_W-1:0]          addr_wdata,
  input  logic                       data_re,
  input  logic                       inc_disable,
  input  logic                       sw_corr_req,
  input  logic [CNT_W-1:0]           err_cnt,
  input  logic [NUM_SYN*DATA_W-1:0]  syn_bus,
  input  logic [NUM_PAIR*DATA_W-1:0] pat_bus,
  input  logic [NUM_PAIR*DATA_W-1:0] loc_bus,
  output logic [ADDR_W-1:0]          addr_q,
  output logic [DATA_W-1:0]          rd_data
);

  // Named internal events, visible to the checker.
  logic        rd_fire;
  logic        inc_fire;
  logic        wr_fire;
  logic [DATA_W-1:0] sel_byte;
  slot_kind_e  sel_kind;

  assign rd_fire  = data_re;
  assign wr_fire  = addr_we;
  assign inc_fire = data_re && !inc_disable;

  ecc_ix_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .wdata    (addr_wdata),
    .inc_fire (inc_fire),
    .addr_q   (addr_q)
  );

  ecc_ix_slot_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SYN(NUM_SYN),
    .NUM_PAIR(NUM_PAIR), .CNT_W(CNT_W)
  ) u_mux (
    .addr        (addr_q),
    .sw_corr_req (sw_corr_req),
    .err_cnt     (err_cnt),
    .syn_bus     (syn_bus),
    .pat_bus     (pat_bus),
    .loc_bus     (loc_bus),
    .sel_byte    (sel_byte),
    .sel_kind    (sel_kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_fire) rd_data <= sel_byte;
  end

endmodule

// File: rtl/ecc_ix_port_chk.sv
module ecc_ix_port_chk
  import ecc_ix_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_fire,
  input logic              rd_fire,
  input logic              inc_disable,
  input logic              sw_corr_req,
  input logic [ADDR_W-1:0] addr_wdata,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] rd_data,
  input slot_kind_e        sel_kind
);

  // R2
  addr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> addr_q == $past(addr_wdata));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !inc_disable && !wr_fire) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  // R5
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && inc_disable && !wr_fire) |=> $stable(addr_q));

  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && sel_kind == SLOT_RSVD) |=> rd_data == '0);

  // R10
  pair_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !sw_corr_req && (sel_kind == SLOT_PAT || sel_kind == SLOT_LOC))
    |=> rd_data == '0);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_data));

endmodule

bind ecc_ix_port ecc_ix_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_fire     (wr_fire),
  .rd_fire     (rd_fire),
  .inc_disable (inc_disable),
  .sw_corr_req (sw_corr_req),
  .addr_wdata  (addr_wdata),
  .addr_q      (addr_q),
  .rd_data     (rd_data),
  .sel_kind    (sel_kind)
);

// File: tb/tb_ecc_ix_port.sv
module tb_ecc_ix_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_we = 1'b0;
  logic [3:0]  addr_wdata = '0;
  logic        data_re = 1'b0;
  logic        inc_disable = 1'b0;
  logic        sw_corr_req = 1'b0;
  logic [1:0]  err_cnt = '0;
  logic [55:0] syn_bus;
  logic [23:0] pat_bus;
  logic [23:0] loc_bus;
  logic [3:0]  addr_q;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ecc_ix_port dut (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wdata(addr_wdata),
    .data_re(data_re), .inc_disable(inc_disable), .sw_corr_req(sw_corr_req),
    .err_cnt(err_cnt), .syn_bus(syn_bus), .pat_bus(pat_bus), .loc_bus(loc_bus),
    .addr_q(addr_q), .rd_data(rd_data)
  );

  function automatic logic [7:0] syn_val(input int i);  return 8'h10 + 8'(i) * 8'h11; endfunction
  function automatic logic [7:0] pat_val(input int k);  return 8'hA1 + 8'(k); endfunction
  function automatic logic [7:0] loc_val(input int k);  return 8'hC5 + 8'(k) * 8'h3; endfunction

  task automatic load_buses();
    for (int i = 0; i < 7; i++) syn_bus[i*8 +: 8] = syn_val(i);
    for (int k = 0; k < 3; k++) begin
      pat_bus[k*8 +: 8] = pat_val(k);
      loc_bus[k*8 +: 8] = loc_val(k);
    end
  endtask

  // Expected byte from the requirement text, not from the RTL.
  function automatic logic [7:0] expect_byte(input int a, input bit req, input int cnt);
    int k;
    if (a <= 6) return syn_val(a);
    if (a <= 9) return 8'h00;
    k = (a - 10) / 2;
    if (!(req && cnt > k)) return 8'h00;
    return ((a % 2) == 0) ? pat_val(k) : loc_val(k);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at negedge, sample shortly after the following posedge.
  task automatic cyc(input bit we, input int wd, input bit re);
    @(negedge clk);
    addr_we = we; addr_wdata = 4'(wd); data_re = re;
    @(posedge clk); #2;
    addr_we = 1'b0; data_re = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 addr", addr_q, 0);
    check("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_write();
    cyc(1, 3, 0);
    check("R2 addr after write", addr_q, 3);
    cyc(1, 12, 0);
    check("R2 addr after write", addr_q, 12);
  endtask

  task automatic t_sweep();
    sw_corr_req = 1'b1; err_cnt = 2'd3; inc_disable = 1'b0;
    cyc(1, 0, 0);
    for (int a = 0; a < 16; a++) begin
      cyc(0, 0, 1);
      if (a <= 6)      check("R7 syndrome slot", rd_data, expect_byte(a, 1, 3));
      else if (a <= 9) check("R8 reserved slot", rd_data, 0);
      else             check("R9 pair slot", rd_data, expect_byte(a, 1, 3));
      if (a == 15) check("R4 wrap", addr_q, 0);
      else         check("R3 increment", addr_q, a + 1);
    end
  endtask

  task automatic t_noinc();
    inc_disable = 1'b1;
    cyc(1, 5, 0);
    cyc(0, 0, 1);
    check("R5 addr held", addr_q, 5);
    check("R5 data", rd_data, syn_val(5));
    cyc(0, 0, 1);
    check("R5 addr held again", addr_q, 5);
    cyc(1, 15, 0);
    cyc(0, 0, 1);
    check("R5 addr held at 15", addr_q, 15);
    inc_disable = 1'b0;
  endtask

  task automatic t_gate();
    sw_corr_req = 1'b0; err_cnt = 2'd3;
    cyc(1, 10, 0); cyc(0, 0, 1);
    check("R10 no request pattern0", rd_data, 0);
    cyc(0, 0, 1);
    check("R10 no request location0", rd_data, 0);
    sw_corr_req = 1'b1; err_cnt = 2'd1;
    cyc(1, 10, 0); cyc(0, 0, 1);
    check("R10 cnt1 pattern0", rd_data, pat_val(0));
    cyc(1, 13, 0); cyc(0, 0, 1);
    check("R10 cnt1 location1", rd_data, 0);
    err_cnt = 2'd2;
    cyc(1, 12, 0); cyc(0, 0, 1);
    check("R10 cnt2 pattern1", rd_data, pat_val(1));
    cyc(1, 14, 0); cyc(0, 0, 1);
    check("R10 cnt2 pattern2", rd_data, 0);
    err_cnt = 2'd0;
    cyc(1, 11, 0); cyc(0, 0, 1);
    check("R10 cnt0 location0", rd_data, 0);
    err_cnt = 2'd3;
  endtask

  task automatic t_collide();
    cyc(1, 4, 0);
    cyc(1, 9, 1);
    check("R6 write wins", addr_q, 9);
    check("R6 data from old address", rd_data, syn_val(4));
  endtask

  task automatic t_hold();
    cyc(1, 2, 0); cyc(0, 0, 1);
    check("R7 read slot 2", rd_data, syn_val(2));
    syn_bus = ~syn_bus;
    cyc(0, 0, 0); cyc(0, 0, 0);
    check("R11 rd_data held", rd_data, syn_val(2));
    load_buses();
  endtask

  initial begin
    load_buses();
    #20;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_write();
    t_sweep();
    t_noinc();
    t_gate();
    t_collide();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule